// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog that resets the system when software stops servicing it. It holds three 32-bit registers on a simple single-cycle bus: a control word, a live count and a timeout limit. While the watchdog is enabled, its up-counter advances on every external tick. When the count reaches the limit, the block raises a one-cycle reset pulse and the counter stops until system reset. Software services the watchdog by writing a refresh key to the count address.

Configuration is guarded. The control and limit registers accept writes only after an unlock key has gone to the count address, and only until the unlock window closes. Keys are either one 32-bit word or two 16-bit halves written in order, chosen by a control bit. Any stray value at the count address while the watchdog runs fires the reset. So does a bad second half in either mode. Two read-only flags show that an unlock is open and that a configuration write has landed. Clearing the update-permit bit freezes the configuration for good.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the control word at offset 0x0 reads 0x0000_0020 (only update-permit bit 5 set), the limit at offset 0x8 reads 0x0000_FFFF, the count at offset 0x4 reads 0 and `wdog_rst_o` is low.
- R2: When bit 13 of the control word is 0, writing 0x0000C520 and then 0x0000D928 to offset 0x4 sets the unlocked flag (bit 11 of offset 0x0).
- R3: When bit 13 is 1, a single write of 0xD928C520 to offset 0x4 sets the unlocked flag.
- R4: A write to offset 0x0 or 0x8 changes the register only while the unlocked flag is 1 and the configuration is not frozen; otherwise the register keeps its value.
- R5: An accepted configuration write sets the reconfigured flag (bit 10) and clears the unlocked flag on the next cycle; the reconfigured flag clears on the next successful unlock.
- R6: The unlocked flag clears by itself UNLOCK_WINDOW (default 128) cycles after the unlock completes.
- R7: If bit 5 of the control word is 0 after an accepted configuration write, every later write to offsets 0x0 and 0x8 is ignored until reset.
- R8: The refresh key clears the count to 0: 0xB480A602 as one word when bit 13 is 1, or 0x0000A602 then 0x0000B480 when bit 13 is 0.
- R9: While enable bit 7 is 1, the count rises by one on each cycle with `tick_en` high; while it is 0, the count holds.
- R10: In the cycle when the count first equals the limit, `wdog_rst_o` is high for exactly one cycle. The count then holds until reset.
- R11: While enabled, any write to offset 0x4 that is neither a key word nor a key first half fires `wdog_rst_o` on the next cycle. While disabled, such a write is ignored.
- R12: In 16-bit mode, a second half that does not complete the key begun by the first half fires `wdog_rst_o` on the next cycle, whether or not the watchdog is enabled.
- R13: Reads return bits 13, 11, 10, 9:8, 7, 5, 1 and 0 of the control word with all other bits zero. Offset 0x4 returns the count, and any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_en | input | 1 | Counter tick from the selected slow clock |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The hardest state to reach is a frozen configuration. It takes three accepted steps: an unlock, a control write with bit 5 cleared, and a second unlock. Only after all three can the bench show that a limit write is dropped while the unlocked flag still reads 1. The bench also runs the unlock window past its full length, and it sends mismatched second halves while the watchdog is disabled. A per-cycle reference model tracks the pending key half, the window count and the halt state, and checks the reset pulse in every cycle.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

  localparam int unsigned WORD_W = 32;

  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_COUNT = 4;
  localparam int unsigned OFS_LIMIT = 8;

  localparam logic [15:0] UNL_FIRST = 16'hC520;
  localparam logic [15:0] UNL_SECOND = 16'hD928;
  localparam logic [15:0] REF_FIRST = 16'hA602;
  localparam logic [15:0] REF_SECOND = 16'hB480;

  typedef struct packed {
    logic       cmd32;
    logic [1:0] clk_sel;
    logic       en;
    logic       upd;
    logic       run_wait;
    logic       run_stop;
  } ctrl_t;

  typedef enum logic [1:0] {HALF_NONE, HALF_UNL, HALF_REF} half_t;

  localparam ctrl_t CTRL_RST = '{cmd32: 1'b0, clk_sel: 2'd0, en: 1'b0,
                                 upd: 1'b1, run_wait: 1'b0, run_stop: 1'b0};

  function automatic logic [WORD_W-1:0] key_word(logic [15:0] lo, logic [15:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic is_half(logic [WORD_W-1:0] w, logic [15:0] k);
    return w == {16'h0000, k};
  endfunction

  function automatic ctrl_t ctrl_from_word(logic [WORD_W-1:0] w);
    ctrl_t c;
    c.cmd32    = w[13];
    c.clk_sel  = w[9:8];
    c.en       = w[7];
    c.upd      = w[5];
    c.run_wait = w[1];
    c.run_stop = w[0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_to_word(ctrl_t c, logic ulk, logic rcs);
    logic [WORD_W-1:0] w;
    w       = '0;
    w[13]   = c.cmd32;
    w[11]   = ulk;
    w[10]   = rcs;
    w[9:8]  = c.clk_sel;
    w[7]    = c.en;
    w[5]    = c.upd;
    w[1]    = c.run_wait;
    w[0]    = c.run_stop;
    return w;
  endfunction

endpackage

// File: rtl/keyed_wdog_keys.sv
module keyed_wdog_keys
  import keyed_wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_count,
  input  logic [WORD_W-1:0] wdata,
  input  logic              cmd32,
  input  logic              enabled,
  output logic              unlock_ev,
  output logic              refresh_ev,
  output logic              violation_ev
);

  half_t half_q, half_d;

  always_comb begin
    unlock_ev    = 1'b0;
    refresh_ev   = 1'b0;
    violation_ev = 1'b0;
    half_d       = cmd32 ? HALF_NONE : half_q;
    if (wr_count) begin
      if (cmd32) begin
        if (wdata == key_word(UNL_FIRST, UNL_SECOND))      unlock_ev    = 1'b1;
        else if (wdata == key_word(REF_FIRST, REF_SECOND)) refresh_ev   = 1'b1;
        else if (enabled)                                  violation_ev = 1'b1;
      end else begin
        unique case (half_q)
          HALF_UNL: begin
            half_d = HALF_NONE;
            if (is_half(wdata, UNL_SECOND)) unlock_ev = 1'b1;
            else violation_ev = 1'b1;
          end
          HALF_REF: begin
            half_d = HALF_NONE;
            if (is_half(wdata, REF_SECOND)) refresh_ev = 1'b1;
            else violation_ev = 1'b1;
          end
          default: begin
            if (is_half(wdata, UNL_FIRST))      half_d = HALF_UNL;
            else if (is_half(wdata, REF_FIRST)) half_d = HALF_REF;
            else if (enabled)                   violation_ev = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= HALF_NONE;
    else        half_q <= half_d;
  end

endmodule

// File: rtl/keyed_wdog_cfg.sv
module keyed_wdog_cfg
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned CNT_W         = 32,
  parameter int unsigned UNLOCK_WINDOW = 128,
  parameter logic [CNT_W-1:0] LIMIT_RST = CNT_W'(32'h0000_FFFF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_limit,
  input  logic [WORD_W-1:0] wdata,
  input  logic              unlock_ev,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  limit,
  output logic              unlocked,
  output logic              reconfigured,
  output logic              accept_ev
);

  localparam int unsigned WIN_W = (UNLOCK_WINDOW > 1) ? $clog2(UNLOCK_WINDOW) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(UNLOCK_WINDOW - 1);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] limit_q;
  logic             ulk_q, rcs_q, frozen_q;
  logic [WIN_W-1:0] win_q;
  ctrl_t            ctrl_next;

  assign accept_ev = (wr_ctrl || wr_limit) && ulk_q && !frozen_q;
  assign ctrl_next = wr_ctrl ? ctrl_from_word(wdata) : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      limit_q  <= LIMIT_RST;
      ulk_q    <= 1'b0;
      rcs_q    <= 1'b0;
      frozen_q <= 1'b0;
      win_q    <= '0;
    end else if (accept_ev) begin
      ctrl_q   <= ctrl_next;
      if (wr_limit) limit_q <= wdata[CNT_W-1:0];
      ulk_q    <= 1'b0;
      rcs_q    <= 1'b1;
      frozen_q <= !ctrl_next.upd;
    end else if (unlock_ev) begin
      ulk_q <= 1'b1;
      rcs_q <= 1'b0;
      win_q <= '0;
    end else if (ulk_q) begin
      if (win_q == WIN_LAST) ulk_q <= 1'b0;
      else                   win_q <= win_q + 1'b1;
    end
  end

  assign ctrl         = ctrl_q;
  assign limit        = limit_q;
  assign unlocked     = ulk_q;
  assign reconfigured = rcs_q;

endmodule

// File: rtl/keyed_wdog_counter.sv
module keyed_wdog_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic             refresh,
  input  logic             violation,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             halted,
  output logic             rst_pulse
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             halt_q, trip;
  logic             pulse_q;

  function automatic logic step_hits(logic [CNT_W-1:0] cur, logic [CNT_W-1:0] lim);
    logic [CNT_W-1:0] nxt;
    nxt = cur + 1'b1;
    return nxt == lim;
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    trip  = 1'b0;
    if (!halt_q) begin
      if (violation) trip = 1'b1;
      if (refresh) begin
        cnt_d = '0;
      end else if (run_en && tick) begin
        cnt_d = cnt_q + 1'b1;
        if (step_hits(cnt_q, limit)) trip = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      halt_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      halt_q  <= halt_q | trip;
      pulse_q <= trip;
    end
  end

  assign count     = cnt_q;
  assign halted    = halt_q;
  assign rst_pulse = pulse_q;

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned CNT_W         = 32,
  parameter int unsigned UNLOCK_WINDOW = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_en,
  output logic              wdog_rst_o
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(OFS_LIMIT);

  logic             wr_any, wr_count, wr_ctrl, wr_limit;
  logic             ev_unlock, ev_refresh, ev_violation, ev_cfg_accept;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] limit_q, cnt_q;
  logic             unlocked, reconfigured, halted;

  assign wr_any   = bus_valid && bus_write;
  assign wr_count = wr_any && (bus_addr == A_COUNT);
  assign wr_ctrl  = wr_any && (bus_addr == A_CTRL);
  assign wr_limit = wr_any && (bus_addr == A_LIMIT);

  keyed_wdog_keys u_keys (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_count     (wr_count),
    .wdata        (bus_wdata),
    .cmd32        (ctrl.cmd32),
    .enabled      (ctrl.en),
    .unlock_ev    (ev_unlock),
    .refresh_ev   (ev_refresh),
    .violation_ev (ev_violation)
  );

  keyed_wdog_cfg #(
    .CNT_W         (CNT_W),
    .UNLOCK_WINDOW (UNLOCK_WINDOW)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr_ctrl),
    .wr_limit     (wr_limit),
    .wdata        (bus_wdata),
    .unlock_ev    (ev_unlock),
    .ctrl         (ctrl),
    .limit        (limit_q),
    .unlocked     (unlocked),
    .reconfigured (reconfigured),
    .accept_ev    (ev_cfg_accept)
  );

  keyed_wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (ctrl.en),
    .tick      (tick_en),
    .refresh   (ev_refresh),
    .violation (ev_violation),
    .limit     (limit_q),
    .count     (cnt_q),
    .halted    (halted),
    .rst_pulse (wdog_rst_o)
  );

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_to_word(ctrl, unlocked, reconfigured);
      A_COUNT: bus_rdata = 32'(cnt_q);
      A_LIMIT: bus_rdata = 32'(limit_q);
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdog_rst_o,
  input logic             ev_unlock,
  input logic             ev_refresh,
  input logic             ev_violation,
  input logic             ev_cfg_accept,
  input logic             unlocked,
  input logic             reconfigured,
  input logic             halted,
  input logic             run_en,
  input logic             tick_en,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] limit_q
);

  assert_unlock_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unlock |=> unlocked);

  assert_limit_change_needs_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(limit_q) |-> $past(ev_cfg_accept));

  assert_accept_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cfg_accept |=> (reconfigured && !unlocked));

  assert_refresh_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_refresh && !halted) |=> (cnt_q == '0));

  assert_tick_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick_en && !ev_refresh && !halted) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |=> !wdog_rst_o);

  assert_halt_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(cnt_q));

  assert_violation_fires_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_violation && !halted) |=> wdog_rst_o);

endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wdog_rst_o    (wdog_rst_o),
  .ev_unlock     (ev_unlock),
  .ev_refresh    (ev_refresh),
  .ev_violation  (ev_violation),
  .ev_cfg_accept (ev_cfg_accept),
  .unlocked      (unlocked),
  .reconfigured  (reconfigured),
  .halted        (halted),
  .run_en        (ctrl.en),
  .tick_en       (tick_en),
  .cnt_q         (cnt_q),
  .limit_q       (limit_q)
);

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;

  localparam int WIN = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_valid = 1'b0, b_write = 1'b0, b_tick = 1'b0;
  logic [3:0]  b_addr = 4'h0;
  logic [31:0] b_wdata = 32'h0;
  logic [31:0] rdata;
  logic        rst_out;

  int n_run = 0, n_fail = 0, pulses = 0;

  always #5 clk = ~clk;

  keyed_wdog u_keyed_wdog (
    .clk (clk), .rst_n (rst_n), .bus_valid (b_valid), .bus_write (b_write),
    .bus_addr (b_addr), .bus_wdata (b_wdata), .bus_rdata (rdata),
    .tick_en (b_tick), .wdog_rst_o (rst_out)
  );

  // reference model state
  bit        m_c32, m_en, m_upd, m_wt, m_st, m_unl, m_rcs, m_frz, m_halt, m_rst;
  bit [1:0]  m_cs;
  bit [31:0] m_lim, m_cnt;
  int        m_win, m_pend;

  task automatic model_reset();
    m_c32 = 0; m_en = 0; m_upd = 1; m_wt = 0; m_st = 0; m_cs = 0;
    m_unl = 0; m_rcs = 0; m_frz = 0; m_halt = 0; m_rst = 0;
    m_lim = 32'hFFFF; m_cnt = 0; m_win = 0; m_pend = 0;
  endtask

  task automatic model_step();
    bit wr, k_unl, k_ref, k_bad, acc, trip;
    int np;
    bit [31:0] nc;
    wr = b_valid && b_write;
    k_unl = 0; k_ref = 0; k_bad = 0; trip = 0;
    np = m_c32 ? 0 : m_pend;
    if (wr && b_addr == 4'h4) begin
      if (m_c32) begin
        if (b_wdata == 32'hD928C520) k_unl = 1;
        else if (b_wdata == 32'hB480A602) k_ref = 1;
        else k_bad = m_en;
      end else if (m_pend == 1) begin
        np = 0; if (b_wdata == 32'hD928) k_unl = 1; else k_bad = 1;
      end else if (m_pend == 2) begin
        np = 0; if (b_wdata == 32'hB480) k_ref = 1; else k_bad = 1;
      end else begin
        if (b_wdata == 32'hC520) np = 1;
        else if (b_wdata == 32'hA602) np = 2;
        else k_bad = m_en;
      end
    end
    acc = wr && (b_addr == 4'h0 || b_addr == 4'h8) && m_unl && !m_frz;
    nc = m_cnt;
    if (!m_halt) begin
      trip = k_bad;
      if (k_ref) nc = 0;
      else if (m_en && b_tick) begin nc = m_cnt + 1; if (nc == m_lim) trip = 1; end
    end
    if (acc) begin
      if (b_addr == 4'h0) begin
        m_c32 = b_wdata[13]; m_cs = b_wdata[9:8]; m_en = b_wdata[7];
        m_upd = b_wdata[5]; m_wt = b_wdata[1]; m_st = b_wdata[0];
      end else m_lim = b_wdata;
      m_rcs = 1; m_unl = 0; m_frz = !m_upd;
    end else if (k_unl) begin
      m_unl = 1; m_rcs = 0; m_win = 0;
    end else if (m_unl) begin
      if (m_win == WIN - 1) m_unl = 0; else m_win++;
    end
    m_cnt = nc; m_rst = trip; m_halt = m_halt | trip; m_pend = np;
  endtask

  function automatic bit [31:0] model_read(bit [3:0] a);
    if (a == 4'h0) return (32'(m_c32) << 13) | (32'(m_unl) << 11) | (32'(m_rcs) << 10) |
                          (32'(m_cs) << 8) | (32'(m_en) << 7) | (32'(m_upd) << 5) |
                          (32'(m_wt) << 1) | 32'(m_st);
    if (a == 4'h4) return m_cnt;
    if (a == 4'h8) return m_lim;
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) model_reset(); else model_step();

  // per-cycle comparison of the reset output against the model (R10, R11, R12)
  always @(negedge clk) if (rst_n) begin
    n_run++;
    if (rst_out) pulses++;
    if (rst_out !== m_rst) begin
      n_fail++;
      $display("FAIL R10/R11/R12 reset output: actual %0b expected %0b at %0t", rst_out, m_rst, $time);
    end
  end

  task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(bit [3:0] a, bit [31:0] d);
    @(negedge clk); b_valid = 1; b_write = 1; b_addr = a; b_wdata = d;
    @(negedge clk); b_valid = 0; b_write = 0;
  endtask

  task automatic rd(bit [3:0] a, bit [31:0] exp, string tag);
    @(negedge clk); b_addr = a; #1;
    check(tag, rdata, exp);
    check({tag, " model"}, rdata, model_read(a));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reboot();
    @(negedge clk); rst_n = 0; b_tick = 0; idle(2); rst_n = 1; idle(1);
  endtask

  task automatic unlock16();
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
  endtask

  int p0;
  bit done = 0;

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1, R13: reset values and layout
    rd(4'h0, 32'h20, "R1 ctrl reset");
    rd(4'h8, 32'hFFFF, "R1 limit reset");
    rd(4'h4, 32'h0, "R1 count reset");
    rd(4'hC, 32'h0, "R13 unmapped read");
    // R4: locked write ignored
    wr(4'h0, 32'h80);
    rd(4'h0, 32'h20, "R4 locked ctrl write ignored");
    // R2: 16-bit unlock
    unlock16();
    rd(4'h0, 32'h820, "R2 unlocked flag");
    // R5: accept sets reconfigured, clears unlocked
    wr(4'h8, 32'd20);
    rd(4'h0, 32'h420, "R5 flags after accept");
    rd(4'h8, 32'd20, "R4 limit written");
    unlock16();
    rd(4'h0, 32'h820, "R5 reconfigured cleared by unlock");
    wr(4'h0, 32'hA3);
    rd(4'h0, 32'h4A3, "R13 ctrl fields");
    // R9: counting
    @(negedge clk); b_tick = 1; idle(5); b_tick = 0;
    rd(4'h4, 32'd5, "R9 count after 5 ticks");
    // R8: 16-bit refresh
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    rd(4'h4, 32'd0, "R8 refresh16 clears");
    // R10: expiry
    p0 = pulses;
    @(negedge clk); b_tick = 1; idle(25); b_tick = 0;
    check("R10 one expiry pulse", pulses - p0, 1);
    rd(4'h4, 32'd20, "R10 count halted at limit");

    // R12: bad second half while disabled
    reboot(); p0 = pulses;
    wr(4'h4, 32'hC520); wr(4'h4, 32'h1234); idle(2);
    check("R12 bad second half pulse", pulses - p0, 1);

    // R11: stray value disabled vs enabled
    reboot(); p0 = pulses;
    wr(4'h4, 32'h5555); idle(2);
    check("R11 stray ignored while disabled", pulses - p0, 0);
    unlock16(); wr(4'h0, 32'hA0);
    wr(4'h4, 32'h5555); idle(2);
    check("R11 stray fires while enabled", pulses - p0, 1);

    // R3: 32-bit key mode
    reboot();
    unlock16(); wr(4'h0, 32'h2020);
    rd(4'h0, 32'h2420, "R3 cmd32 set");
    wr(4'h4, 32'hD928C520);
    rd(4'h0, 32'h2820, "R3 unlock32");
    wr(4'h0, 32'h20A0);
    @(negedge clk); b_tick = 1; idle(3); b_tick = 0;
    rd(4'h4, 32'd3, "R9 count in 32-bit mode");
    wr(4'h4, 32'hB480A602);
    rd(4'h4, 32'd0, "R8 refresh32 clears");
    p0 = pulses;
    wr(4'h4, 32'h0000C520); idle(2);
    check("R11 half key rejected in 32-bit mode", pulses - p0, 1);

    // R6: window expiry
    reboot();
    unlock16(); idle(WIN + 4);
    rd(4'h0, 32'h20, "R6 window closed");
    wr(4'h8, 32'd5);
    rd(4'h8, 32'hFFFF, "R6 late write ignored");

    // R7: freeze
    reboot();
    unlock16(); wr(4'h0, 32'h0);
    unlock16();
    rd(4'h0, 32'h800, "R7 unlock after freeze");
    wr(4'h8, 32'd7);
    rd(4'h8, 32'hFFFF, "R7 frozen limit");
    rd(4'h0, 32'h800, "R7 still unlocked, no accept");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule